// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

This block reduces a wide vector of level-sensitive interrupt lines to one request line per group of eight. Each group output is the OR of that group's inputs that are both high and enabled. Software owns the enable bits through a small register port with valid, write, address and write-data signals and a registered read response. It can switch enables on and off without a read-modify-write, because setting and clearing use separate write-one addresses.

Groups are packed four to a 32-bit bank. Group `n` occupies bits `(n mod 4)*8` to `(n mod 4)*8+7` of bank `n div 4`. Bank `k` starts at byte offset `k*0x10`. Input `i` of the flat input vector belongs to group `i div 8`, bit `i mod 8`. The register port runs a two-state machine. In `PORT_IDLE` no response is shown. A read request moves it to `PORT_RESP` (transition IDLE→RESP). While it is in `PORT_RESP`, another read keeps it there (RESP→RESP) and a cycle without a read returns it to idle (RESP→IDLE). Writes take effect in either state and never change the state.

Top module: `interrupt_combiner`

## Requirements
- R1: After reset every enable bit is 0, every group output is low and `rsp_valid` is low.
- R2: A write to bank offset 0x0 sets each enable bit whose write-data bit is 1 and leaves bits written with 0 unchanged.
- R3: A write to bank offset 0x4 clears each enable bit whose write-data bit is 1 and leaves bits written with 0 unchanged.
- R4: Reads of bank offset 0x0 or 0x4 return the bank's current enable bits. Group `n` sits in bank `n div 4` (base `k*0x10`) at bits `(n mod 4)*8` upward.
- R5: Reads of bank offset 0xC return the bank's captured inputs ANDed with their enable bits, so a high but disabled input reads 0. Writes to 0xC change nothing.
- R6: A group output is high exactly while at least one of its enabled inputs is high (level behaviour), and disabled inputs have no effect on it.
- R7: An input change reaches the group output two clock edges after it is applied. An enable write reaches the output one edge after the write is accepted.
- R8: Offset 0x8, any address whose two low bits are not zero, banks past the last one, and the lanes of groups beyond the group count all read as 0 and ignore writes.
- R9: Every read request accepted at an edge is followed by `rsp_valid` high with its data for the next cycle. Writes never raise `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq_in | input | NUM_GROUPS*8 | Level interrupt inputs |
| grp_irq | output | NUM_GROUPS | One request per group |

## Verification
The bench builds the block with six groups, so it has one full bank and one half-filled bank. This makes the unimplemented upper lanes of the last bank reachable, along with an address past the last bank. A vector table runs enable and input patterns over both banks and checks the outputs and the status words. Directed tests then cover reset, set and clear masking, the offset hole, unaligned addresses, status-write immunity, exact latency and back-to-back reads.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
    localparam int GROUP_W         = 8;
    localparam int GROUPS_PER_BANK = 4;
    localparam int BANK_W          = GROUP_W * GROUPS_PER_BANK;

    // word select taken from address bits [3:2]
    typedef enum logic [1:0] {
        REG_SET  = 2'd0,
        REG_CLR  = 2'd1,
        REG_HOLE = 2'd2,
        REG_STAT = 2'd3
    } reg_word_e;

    typedef enum logic {
        PORT_IDLE = 1'b0,
        PORT_RESP = 1'b1
    } port_state_e;

    // lanes of a bank that belong to groups that actually exist
    function automatic logic [BANK_W-1:0] lane_mask(input int bank, input int n_groups);
        logic [BANK_W-1:0] m;
        m = '0;
        for (int i = 0; i < GROUPS_PER_BANK; i++) begin
            if (bank * GROUPS_PER_BANK + i < n_groups) begin
                m[i*GROUP_W +: GROUP_W] = '1;
            end
        end
        return m;
    endfunction
endpackage

// File: rtl/cmb_enable_bank.sv
module cmb_enable_bank
    import cmb_pkg::*;
#(
    parameter logic [BANK_W-1:0] LANE_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [BANK_W-1:0] wr_data,
    input  logic [BANK_W-1:0] pend,
    output logic [BANK_W-1:0] en,
    output logic [BANK_W-1:0] stat
);
    logic [BANK_W-1:0] en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (set_we) begin
            en_q <= (en_q | wr_data) & LANE_MASK;
        end else if (clr_we) begin
            en_q <= en_q & ~wr_data;
        end
    end

    assign en   = en_q;
    assign stat = pend & en_q;
endmodule

// File: rtl/cmb_group_or.sv
module cmb_group_or
    import cmb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [GROUP_W-1:0] gated,
    output logic               req
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= |gated;
        end
    end

    assign req = req_q;
endmodule

// File: rtl/cmb_regport.sv
module cmb_regport
    import cmb_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [BANK_W-1:0]           req_wdata,
    input  logic [NUM_BANKS*BANK_W-1:0] en_flat,
    input  logic [NUM_BANKS*BANK_W-1:0] stat_flat,
    output logic [NUM_BANKS-1:0]        set_we,
    output logic [NUM_BANKS-1:0]        clr_we,
    output logic [BANK_W-1:0]           wr_data,
    output logic                        rsp_valid,
    output logic [BANK_W-1:0]           rsp_rdata
);
    localparam int BSEL_W = ADDR_W - 4;

    port_state_e       state_q, state_d;
    reg_word_e         word;
    logic [BSEL_W-1:0] bank_idx;
    logic              aligned;
    logic              rd_fire, wr_fire;
    logic [NUM_BANKS-1:0] bank_sel;
    logic [BANK_W-1:0] rd_next;
    logic [BANK_W-1:0] rdata_q;

    assign word     = reg_word_e'(req_addr[3:2]);
    assign bank_idx = req_addr[ADDR_W-1:4];
    assign aligned  = (req_addr[1:0] == 2'b00);
    assign rd_fire  = req_valid && !req_write;
    assign wr_fire  = req_valid && req_write;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
        assign bank_sel[b] = aligned && (int'(bank_idx) == b);
    end

    assign set_we  = (wr_fire && word == REG_SET) ? bank_sel : '0;
    assign clr_we  = (wr_fire && word == REG_CLR) ? bank_sel : '0;
    assign wr_data = req_wdata;

    always_comb begin
        rd_next = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_sel[b]) begin
                unique case (word)
                    REG_SET, REG_CLR: rd_next = en_flat[b*BANK_W +: BANK_W];
                    REG_STAT:         rd_next = stat_flat[b*BANK_W +: BANK_W];
                    default:          rd_next = '0;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PORT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_IDLE: if (rd_fire)  state_d = PORT_RESP;
            PORT_RESP: if (!rd_fire) state_d = PORT_IDLE;
            default:   state_d = PORT_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_fire) begin
            rdata_q <= rd_next;
        end
    end

    assign rsp_valid = (state_q == PORT_RESP);
    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/interrupt_combiner.sv
module interrupt_combiner
    import cmb_pkg::*;
#(
    parameter int NUM_GROUPS = 20,
    parameter int ADDR_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [31:0]                   req_wdata,
    output logic                          rsp_valid,
    output logic [31:0]                   rsp_rdata,
    input  logic [NUM_GROUPS*GROUP_W-1:0] irq_in,
    output logic [NUM_GROUPS-1:0]         grp_irq
);
    localparam int NUM_BANKS = (NUM_GROUPS + GROUPS_PER_BANK - 1) / GROUPS_PER_BANK;
    localparam int NUM_IN    = NUM_GROUPS * GROUP_W;
    localparam int TOT_W     = NUM_BANKS * BANK_W;

    logic [TOT_W-1:0]     pend_pad, pend_q;
    logic [TOT_W-1:0]     en_flat, stat_flat;
    logic [NUM_BANKS-1:0] set_we, clr_we;
    logic [BANK_W-1:0]    wr_data;

    always_comb begin
        pend_pad = '0;
        pend_pad[NUM_IN-1:0] = irq_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_pad;
        end
    end

    cmb_regport #(
        .NUM_BANKS(NUM_BANKS),
        .ADDR_W   (ADDR_W)
    ) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .en_flat  (en_flat),
        .stat_flat(stat_flat),
        .set_we   (set_we),
        .clr_we   (clr_we),
        .wr_data  (wr_data),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        cmb_enable_bank #(
            .LANE_MASK(lane_mask(b, NUM_GROUPS))
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (set_we[b]),
            .clr_we (clr_we[b]),
            .wr_data(wr_data),
            .pend   (pend_q[b*BANK_W +: BANK_W]),
            .en     (en_flat[b*BANK_W +: BANK_W]),
            .stat   (stat_flat[b*BANK_W +: BANK_W])
        );
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        cmb_group_or u_or (
            .clk  (clk),
            .rst_n(rst_n),
            .gated(stat_flat[g*GROUP_W +: GROUP_W]),
            .req  (grp_irq[g])
        );
    end
endmodule

// File: rtl/cmb_checker.sv
module cmb_checker #(
    parameter int NUM_GROUPS = 20,
    parameter int ADDR_W     = 8,
    parameter int NUM_BANKS  = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_write,
    input logic [ADDR_W-1:0]       req_addr,
    input logic [31:0]             req_wdata,
    input logic                    rsp_valid,
    input logic [NUM_BANKS*32-1:0] en_flat,
    input logic [NUM_GROUPS-1:0]   grp_irq
);
    // R9
    read_gets_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R9
    response_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    // R5
    status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr[3:2] == 2'b11) |=> $stable(en_flat));

    // R8
    hole_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr[3:2] == 2'b10) |=> $stable(en_flat));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
        // R3
        clear_wipes_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_write && req_addr[3:0] == 4'h4 && int'(req_addr[ADDR_W-1:4]) == b)
            |=> ((en_flat[b*32 +: 32] & $past(req_wdata)) == 32'h0));

        // R2
        set_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_write && req_addr[3:0] == 4'h0 && int'(req_addr[ADDR_W-1:4]) == b)
            |=> (($past(en_flat[b*32 +: 32]) & ~en_flat[b*32 +: 32]) == 32'h0));
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp_chk
        // R6
        group_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grp_irq[g] |-> $past(|en_flat[g*8 +: 8]));
    end
endmodule

bind interrupt_combiner cmb_checker #(
    .NUM_GROUPS(NUM_GROUPS),
    .ADDR_W    (ADDR_W),
    .NUM_BANKS (NUM_BANKS)
) u_cmb_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid),
    .en_flat  (en_flat),
    .grp_irq  (grp_irq)
);

// File: tb/interrupt_combiner_test.sv
module interrupt_combiner_test;
    localparam int NG = 6;
    localparam int AW = 8;
    localparam int NI = NG * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic [NI-1:0] irq_in = '0;
    logic [NG-1:0] grp_irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    interrupt_combiner #(.NUM_GROUPS(NG), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .irq_in(irq_in), .grp_irq(grp_irq)
    );

    // fields: inputs[48], bank0 enables[32], bank1 enables[16], expected groups[6]
    localparam logic [101:0] VEC [6] = '{
        {48'h0000_0000_0000, 32'hFFFF_FFFF, 16'hFFFF, 6'b000000},
        {48'h0000_0000_0001, 32'h0000_0001, 16'h0000, 6'b000001},
        {48'h8000_8000_0000, 32'h8000_0000, 16'h8000, 6'b101000},
        {48'hFFFF_FFFF_FFFF, 32'h0000_0000, 16'h0000, 6'b000000},
        {48'h00FF_00FF_0000, 32'h0001_0000, 16'h0100, 6'b000100},
        {48'h0100_0000_0100, 32'h0000_FF00, 16'hFF00, 6'b100010}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        v = rsp_valid;
        d = rsp_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 grp after reset", 64'(grp_irq), 64'h0);
        chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'h0);
        rd(8'h00, d, v); chk("R1 bank0 enables", 64'(d), 64'h0);
        rd(8'h10, d, v); chk("R1 bank1 enables", 64'(d), 64'h0);

        // table walk: R6 outputs, R5 status, R4 layout
        for (int i = 0; i < 6; i++) begin
            wr(8'h04, 32'hFFFF_FFFF);
            wr(8'h14, 32'hFFFF_FFFF);
            wr(8'h00, VEC[i][53:22]);
            wr(8'h10, {16'h0, VEC[i][21:6]});
            irq_in = VEC[i][101:54];
            repeat (3) @(negedge clk);
            chk($sformatf("R6 vec%0d groups", i), 64'(grp_irq), 64'(VEC[i][5:0]));
            rd(8'h0C, d, v);
            chk($sformatf("R5 vec%0d bank0 status", i), 64'(d), 64'(VEC[i][85:54] & VEC[i][53:22]));
            rd(8'h1C, d, v);
            chk($sformatf("R5 vec%0d bank1 status", i), 64'(d), 64'({16'h0, VEC[i][101:86] & VEC[i][21:6]}));
            rd(8'h10, d, v);
            chk($sformatf("R4 vec%0d bank1 enables", i), 64'(d), 64'({16'h0, VEC[i][21:6]}));
        end
        irq_in = '0;

        // R2 / R3 masking
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h00, 32'h0000_000F);
        wr(8'h00, 32'h0000_00F0);
        rd(8'h00, d, v); chk("R2 set with zeros keeps bits", 64'(d), 64'hFF);
        wr(8'h04, 32'h0000_0030);
        rd(8'h00, d, v); chk("R3 clear only ones", 64'(d), 64'hCF);
        rd(8'h04, d, v); chk("R4 clear offset reads enables", 64'(d), 64'hCF);
        chk("R9 read gives rsp_valid", 64'(v), 64'h1);

        // R5 status write ignored, R8 hole / unaligned / out of range / dead lanes
        wr(8'h0C, 32'h0000_0000);
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_FFFF);
        rd(8'h00, d, v); chk("R5 R8 writes leave enables", 64'(d), 64'hCF);
        rd(8'h08, d, v); chk("R8 hole reads zero", 64'(d), 64'h0);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, d, v); chk("R8 missing lanes read zero", 64'(d), 64'h0000_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, d, v); chk("R8 bank past end reads zero", 64'(d), 64'h0);
        chk("R9 out-of-range read still answered", 64'(v), 64'h1);

        // R9 back-to-back reads then idle, writes give no response
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h00;
        @(negedge clk);
        req_addr = 8'h10;
        chk("R9 first read data", 64'({rsp_valid, rsp_rdata}), {31'h0, 1'b1, 32'hCF});
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 second read data", 64'({rsp_valid, rsp_rdata}), {31'h0, 1'b1, 32'hFFFF});
        @(negedge clk);
        chk("R9 idle after reads", 64'(rsp_valid), 64'h0);
        wr(8'h00, 32'h0);
        chk("R9 write no response", 64'(rsp_valid), 64'h0);

        // R7 latency and R6 level hold
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h00, 32'h0000_0001);
        repeat (2) @(negedge clk);
        irq_in[0] = 1'b1;
        @(negedge clk);
        chk("R7 one edge after input", 64'(grp_irq), 64'h0);
        @(negedge clk);
        chk("R7 two edges after input", 64'(grp_irq), 64'h1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R6 level held", 64'(grp_irq), 64'h1);
        end
        wr(8'h04, 32'h0000_0001);
        chk("R7 enable clear not yet seen", 64'(grp_irq), 64'h1);
        @(negedge clk);
        chk("R7 enable clear one edge later", 64'(grp_irq), 64'h0);
        wr(8'h00, 32'h0000_0001);
        @(negedge clk);
        chk("R6 re-enabled high input", 64'(grp_irq), 64'h1);
        irq_in[0] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 input low drops output", 64'(grp_irq), 64'h0);

        // R1 reset clears enables again
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(8'h00, d, v); chk("R1 enables cleared by reset", 64'(d), 64'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule